// File: doc/BRIEF.md
# General Register File with Write-Source Selection

This block is the general-purpose register storage for a small 10-bit processor: four registers of 10 bits each. Two read ports are addressed independently with 2 bits each. Each port shows its register's contents on its output bus at all times, with no read strobe. The two ports let the ALU take both of its operands in the same cycle.

There is a single write port. A built-in four-way selector picks the write data from one of four producers: the ALU result, the memory read word, the 4-bit address field of the current instruction, or the 4-bit program counter. The two 4-bit producers are zero-extended to 10 bits. When the write enable is high, the selected word is stored into the addressed register at the rising clock edge. A synchronous reset clears every register.

Top module: `gpr_file`

## Requirements
- R1: When `rst` is high at a rising edge, all four registers read as zero after that edge.
- R2: When `wr_en` is high at a rising edge, the addressed register holds the selected source word after that edge.
- R3: When `wr_en` is low at a rising edge, no register changes.
- R4: A write changes only the register named by `wr_addr`; the other three keep their values.
- R5: `wr_src` = 0 selects `alu_data` as the write word.
- R6: `wr_src` = 1 selects `mem_data` as the write word.
- R7: `wr_src` = 2 selects `ir_field` zero-extended: bits 3:0 come from the field and bits 9:4 are zero.
- R8: `wr_src` = 3 selects `pc_val` zero-extended: bits 3:0 come from the counter and bits 9:4 are zero.
- R9: Both read ports are combinational and independent. Each shows the register named by its own address, and both ports may name the same register.
- R10: In the cycle a register is being written, a read of that register returns the value it held before the edge. The new value is not forwarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, clears all registers |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 2 | Register to write |
| wr_src | input | 2 | Write source: 0 ALU, 1 memory, 2 instruction field, 3 program counter |
| alu_data | input | 10 | ALU result |
| mem_data | input | 10 | Memory read word |
| ir_field | input | 4 | Address field of the current instruction |
| pc_val | input | 4 | Program counter value |
| rd_a_addr | input | 2 | Read port A address |
| rd_b_addr | input | 2 | Read port B address |
| rd_a_data | output | 10 | Read port A data |
| rd_b_data | output | 10 | Read port B data |

## Verification
The assertions assume that every control input (`wr_en`, `wr_addr`, `wr_src`) is a known 0/1 value at each rising edge outside reset. They also assume that reset is held across the first edge, so stored state starts defined. The stimulus changes inputs only on falling edges, holds reset for several cycles at the start, and draws every address, source code and data word from the defined range. It mixes directed writes of each source into each register with long random runs and a reset in the middle of the run.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
    typedef enum logic [1:0] {
        SRC_ALU = 2'd0,
        SRC_MEM = 2'd1,
        SRC_IRF = 2'd2,
        SRC_PC  = 2'd3
    } wr_src_e;
endpackage

// File: rtl/gpr_src_mux.sv
module gpr_src_mux
    import gpr_pkg::*;
#(
    parameter int W     = 10,
    parameter int IRF_W = 4,
    parameter int PC_W  = 4
) (
    input  wr_src_e          sel,
    input  logic [W-1:0]     alu_data,
    input  logic [W-1:0]     mem_data,
    input  logic [IRF_W-1:0] ir_field,
    input  logic [PC_W-1:0]  pc_val,
    output logic [W-1:0]     word
);
    localparam int IRF_PAD = W - IRF_W;
    localparam int PC_PAD  = W - PC_W;

    always_comb begin
        unique case (sel)
            SRC_ALU: word = alu_data;
            SRC_MEM: word = mem_data;
            SRC_IRF: word = {{IRF_PAD{1'b0}}, ir_field};
            default: word = {{PC_PAD{1'b0}}, pc_val};
        endcase
    end
endmodule

// File: rtl/gpr_store.sv
module gpr_store #(
    parameter int N  = 4,
    parameter int W  = 10,
    parameter int AW = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [AW-1:0]       waddr,
    input  logic [W-1:0]        wdata,
    output logic [N-1:0][W-1:0] mem
);
    typedef struct packed {
        logic [N-1:0][W-1:0] mem;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.mem = '0;
        end else if (we) begin
            st_d.mem[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mem = st_q.mem;

    AST_WRITE_COMMIT: assert property (@(posedge clk) disable iff (rst)
        we |=> st_q.mem[$past(waddr)] == $past(wdata)); // R2

    for (genvar i = 0; i < N; i++) begin : g_entry_chk
        AST_RESET_CLEAR: assert property (@(posedge clk)
            rst |=> st_q.mem[i] == '0); // R1
        AST_HOLD_UNSELECTED: assert property (@(posedge clk) disable iff (rst)
            !(we && (waddr == AW'(i))) |=> $stable(st_q.mem[i])); // R3
    end
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
    parameter int N  = 4,
    parameter int W  = 10,
    parameter int AW = 2
) (
    input  logic [N-1:0][W-1:0] mem,
    input  logic [AW-1:0]       addr,
    output logic [W-1:0]        data
);
    always_comb begin
        data = mem[addr];
    end
endmodule

// File: rtl/gpr_file.sv
module gpr_file
    import gpr_pkg::*;
#(
    parameter int N     = 4,
    parameter int W     = 10,
    parameter int IRF_W = 4,
    parameter int PC_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [$clog2(N)-1:0] wr_addr,
    input  logic [1:0]           wr_src,
    input  logic [W-1:0]         alu_data,
    input  logic [W-1:0]         mem_data,
    input  logic [IRF_W-1:0]     ir_field,
    input  logic [PC_W-1:0]      pc_val,
    input  logic [$clog2(N)-1:0] rd_a_addr,
    input  logic [$clog2(N)-1:0] rd_b_addr,
    output logic [W-1:0]         rd_a_data,
    output logic [W-1:0]         rd_b_data
);
    localparam int AW = $clog2(N);

    logic [W-1:0]        wr_word;
    logic [N-1:0][W-1:0] mem;

    gpr_src_mux #(.W(W), .IRF_W(IRF_W), .PC_W(PC_W)) u_mux (
        .sel      (wr_src_e'(wr_src)),
        .alu_data (alu_data),
        .mem_data (mem_data),
        .ir_field (ir_field),
        .pc_val   (pc_val),
        .word     (wr_word)
    );

    gpr_store #(.N(N), .W(W), .AW(AW)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_word),
        .mem   (mem)
    );

    gpr_read_port #(.N(N), .W(W), .AW(AW)) u_rd_a (
        .mem  (mem),
        .addr (rd_a_addr),
        .data (rd_a_data)
    );

    gpr_read_port #(.N(N), .W(W), .AW(AW)) u_rd_b (
        .mem  (mem),
        .addr (rd_b_addr),
        .data (rd_b_data)
    );

    AST_IRF_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
        (wr_src == 2'd2) |-> (wr_word[W-1:IRF_W] == '0)); // R7
    AST_PC_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
        (wr_src == 2'd3) |-> (wr_word[W-1:PC_W] == '0)); // R8
endmodule

// File: tb/gpr_file_tb.sv
module gpr_file_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [1:0] wr_addr, wr_src, rd_a_addr, rd_b_addr;
    logic [9:0] alu_data, mem_data, rd_a_data, rd_b_data;
    logic [3:0] ir_field, pc_val;

    int checks = 0;
    int fails  = 0;
    logic [9:0] model [4];
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    gpr_file u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_src(wr_src),
        .alu_data(alu_data), .mem_data(mem_data), .ir_field(ir_field), .pc_val(pc_val),
        .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data)
    );

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] pick(input logic [1:0] s);
        case (s)
            2'd0: return alu_data;
            2'd1: return mem_data;
            2'd2: return {6'd0, ir_field};
            default: return {6'd0, pc_val};
        endcase
    endfunction

    function automatic string src_tag(input logic [1:0] s);
        case (s)
            2'd0: return "R2 R5";
            2'd1: return "R2 R6";
            2'd2: return "R2 R7";
            default: return "R2 R8";
        endcase
    endfunction

    // previous-cycle write context, used to tag read checks
    bit         last_we = 0;
    bit         last_rst = 1;
    logic [1:0] last_addr = '0;
    logic [1:0] last_src = '0;

    function automatic string tag_for(input logic [1:0] a);
        if (last_rst) return "R1";
        if (!last_we) return "R3 R9";
        if (last_addr == a) return src_tag(last_src);
        return "R4 R9";
    endfunction

    // one cycle: inputs already set at negedge; compare reads, clock, update model
    task automatic step();
        #2;
        check(tag_for(rd_a_addr), rd_a_data, model[rd_a_addr]);
        check(tag_for(rd_b_addr), rd_b_data, model[rd_b_addr]);
        if (!rst && wr_en && (rd_a_addr == wr_addr))
            check("R10", rd_a_data, model[wr_addr]);
        @(posedge clk);
        #1;
        if (rst) begin
            for (int k = 0; k < 4; k++) model[k] = '0;
        end else if (wr_en) begin
            model[wr_addr] = pick(wr_src);
        end
        last_rst  = rst;
        last_we   = wr_en;
        last_addr = wr_addr;
        last_src  = wr_src;
        @(negedge clk);
    endtask

    task automatic drive(input bit r, input bit we, input logic [1:0] wa, input logic [1:0] ws,
                         input logic [1:0] ra, input logic [1:0] rb);
        rst = r; wr_en = we; wr_addr = wa; wr_src = ws; rd_a_addr = ra; rd_b_addr = rb;
        alu_data = 10'($urandom); mem_data = 10'($urandom);
        ir_field = 4'($urandom);  pc_val = 4'($urandom);
    endtask

    initial begin
        for (int k = 0; k < 4; k++) model[k] = '0;
        drive(1, 0, 0, 0, 0, 1);
        @(negedge clk);
        for (int c = 0; c < 3; c++) step();
        // R1: reset state on all entries
        for (int k = 0; k < 4; k++) begin
            drive(0, 0, 0, 0, 2'(k), 2'(3 - k));
            step();
        end
        // directed: each source into each register, then read back both ports
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < 4; k++) begin
                drive(0, 1, 2'(k), 2'(s), 2'(k), 2'(k));
                alu_data = 10'h3FF; mem_data = 10'h2A5; ir_field = 4'hF; pc_val = 4'hA;
                step();
                drive(0, 0, 0, 0, 2'(k), 2'(k));
                step();
            end
        end
        // random run with a reset in the middle
        for (int c = 0; c < 2000; c++) begin
            drive((c == 1000), 1'($urandom), 2'($urandom), 2'($urandom),
                  2'($urandom), 2'($urandom));
            step();
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule